// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the register file of an asynchronous serial port. It sits between a byte-wide register bus and two separate engines, one that shifts characters out and one that shifts them in. It holds the configuration that those engines read: framing and clock selection, the bit-rate divisor, the enables, and two pass-through configuration bytes for smart-card and extended operation. It also keeps the port's flags: transmit buffer empty, transmission finished, receive buffer full, and three error flags. The rules for setting and clearing those flags are applied here. From the flags and the enable bits it drives four interrupt lines.

Software reaches eight byte registers through a single-cycle bus strobe. A write takes effect at the clock edge that ends the strobe cycle. Read data is combinational from the address. Two reads have side effects: a status read captures the error bits for the later clear handshake, and a receive-data read empties the receive buffer.

The transmit data path is a valid/ready stream. `tx_valid` is high while a byte is pending and transmission is enabled. The engine takes the byte by raising `tx_ready`, and may hold `tx_ready` low for as long as it needs. The receive path is also a valid/ready stream. `rx_ready` follows the receive enable, so with reception disabled the engine is held off and no byte is lost. With reception enabled every offered byte is accepted at once. If the buffer is still full, the byte is discarded and counted as an overrun.

Top module: `sio_regs`

## Requirements
- R1: After reset the eight registers read: offset 0 (mode) 0x00, offset 1 (bit-rate) 0xFF, offset 2 (control) 0x00, offset 3 (transmit data) 0xFF, offset 4 (status) 0x84, offset 5 (receive data) 0x00, offset 6 (smart-card) 0x00, offset 7 (extended) 0x00. All four interrupt outputs are low.
- R2: Writes to offsets 0 and 1 are ignored while control bit 4 (receive enable) or bit 5 (transmit enable) is set. With both clear, these writes take effect.
- R3: A control write with bit 5 set forces status bit 7 (transmit empty) and status bit 2 (transmit end) to 1. If that write also sets bit 7 (transmit interrupt enable), `irq_tx_empty` pulses for one cycle after the write.
- R4: A write to offset 3 stores the byte and clears status bit 7. While bit 7 is 0 and transmit enable is set, `tx_valid` is high and `tx_data` shows the byte. A handshake sets bit 7, clears bit 2, and pulses `irq_tx_empty` when control bit 7 is set.
- R5: When `tx_done` is high and status bit 7 is 1, status bit 2 is set, and `irq_tx_end` rises if control bit 2 is set. `tx_done` while bit 7 is 0 has no effect. `irq_tx_end` falls on a control write with bit 2 clear, or on the next transmit handshake.
- R6: `rx_ready` equals control bit 4. An accepted byte with status bit 6 (receive full) clear is stored and sets bit 6. It pulses `irq_rx_full` for one cycle only when control bit 6 (receive interrupt enable) is set.
- R7: A byte accepted while status bit 6 is set is discarded: the stored byte is kept, status bit 5 (overrun) is set, and `irq_rx_err` rises if control bit 6 is set.
- R8: A `rx_break` pulse sets status bit 4 (framing error). A stored byte flagged by `rx_perr` sets status bit 3 (parity error). Either event raises `irq_rx_err` when control bit 6 is set.
- R9: A read of offset 5 clears status bit 6. Writes to offset 5 change nothing.
- R10: A status write copies data bit 0 into status bit 0. An error bit (bits 5..3) is cleared only if it is written 0 and was 1 at the most recent status read. Writing 1 never sets an error bit, and bits 7, 6, 2 and 1 are unaffected.
- R11: `irq_rx_err` is released by a status write that leaves all three error bits zero when the last status read saw at least one of them set. It is also released by a control write with bit 6 clear.
- R12: Offsets 8 and above read 0xFF, and writes to them change no register.
- R13: Offsets 6 and 7 read back the last byte written to them and drive `cfg_scm` and `cfg_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tx_valid | output | 1 | A byte is pending for the transmit engine |
| tx_ready | input | 1 | Transmit engine takes the pending byte |
| tx_data | output | 8 | Pending transmit byte |
| tx_done | input | 1 | Transmit engine finished the character on the line |
| rx_valid | input | 1 | Receive engine offers a byte |
| rx_ready | output | 1 | Receive path accepts bytes (receive enabled) |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Offered byte has a parity error |
| rx_break | input | 1 | Framing error or break detected, one-cycle pulse |
| cfg_mode | output | 8 | Mode byte to the engines |
| cfg_baud | output | 8 | Bit-rate divisor to the engines |
| cfg_ctrl | output | 8 | Control byte |
| cfg_scm | output | 8 | Smart-card configuration byte |
| cfg_ext | output | 8 | Extended configuration byte |
| irq_rx_err | output | 1 | Receive error interrupt, level |
| irq_rx_full | output | 1 | Receive full interrupt, one-cycle pulse |
| irq_tx_empty | output | 1 | Transmit empty interrupt, one-cycle pulse |
| irq_tx_end | output | 1 | Transmit end interrupt, level |

## Verification
The bench builds the block with `ADDR_W` = 4 instead of the default 3. This puts offsets 8 to 15 on the bus, so the 0xFF read and the ignored writes of R12 can be exercised. Reset values of the bit-rate and transmit data registers stay at their defaults so R1 checks them. The stimulus walks the status byte through lock, handshake, overrun, break and parity sequences. Each status read is compared against a value computed from the bit positions in the requirements.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW    = 8;
  localparam int ERR_W = 3;

  typedef enum logic [2:0] {
    OFS_MODE = 3'd0,
    OFS_BAUD = 3'd1,
    OFS_CTRL = 3'd2,
    OFS_TXD  = 3'd3,
    OFS_STAT = 3'd4,
    OFS_RXD  = 3'd5,
    OFS_SCM  = 3'd6,
    OFS_EXT  = 3'd7
  } ofs_e;

  // control byte bit positions
  localparam int C_TEIE = 2;
  localparam int C_RE   = 4;
  localparam int C_TE   = 5;
  localparam int C_RIE  = 6;
  localparam int C_TIE  = 7;

  // status byte bit positions
  localparam int S_MPBT = 0;
  localparam int S_MPB  = 1;
  localparam int S_TEND = 2;
  localparam int S_ERR0 = 3;
  localparam int S_RDRF = 6;
  localparam int S_TDRE = 7;
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_pkg::*;
#(
  parameter logic [DW-1:0] BAUD_RST = '1,
  parameter logic [DW-1:0] TXD_RST  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic          baud_we,
  input  logic          ctrl_we,
  input  logic          txd_we,
  input  logic          scm_we,
  input  logic          ext_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] baud_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] txd_q,
  output logic [DW-1:0] scm_q,
  output logic [DW-1:0] ext_q
);
  logic locked;
  assign locked = ctrl_q[C_TE] | ctrl_q[C_RE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      baud_q <= BAUD_RST;
      ctrl_q <= '0;
      txd_q  <= TXD_RST;
      scm_q  <= '0;
      ext_q  <= '0;
    end else begin
      if (mode_we && !locked) mode_q <= wdata;
      if (baud_we && !locked) baud_q <= wdata;
      if (ctrl_we)            ctrl_q <= wdata;
      if (txd_we)             txd_q  <= wdata;
      if (scm_we)             scm_q  <= wdata;
      if (ext_we)             ext_q  <= wdata;
    end
  end

  p_lock_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && locked) |=> $stable(mode_q));
  p_lock_baud_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_we && locked) |=> $stable(baud_q));
endmodule

// File: rtl/sio_flags.sv
module sio_flags
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             te_en,
  input  logic             re_en,
  input  logic             txd_we,
  input  logic             stat_we,
  input  logic             stat_re,
  input  logic             rxd_re,
  input  logic             te_set,
  input  logic             mpbt_wd,
  input  logic [ERR_W-1:0] err_wd,
  input  logic             tx_ready,
  input  logic             tx_done,
  input  logic             rx_valid,
  input  logic             rx_perr,
  input  logic             rx_break,
  input  logic [DW-1:0]    rx_data,
  output logic             tx_valid,
  output logic             rx_ready,
  output logic             tx_take,
  output logic [DW-1:0]    stat_q,
  output logic [DW-1:0]    rxd_q,
  output logic             rx_store,
  output logic             err_evt,
  output logic             err_clr_evt,
  output logic             tend_evt
);
  logic             tdre_q, tend_q, rdrf_q, mpbt_q;
  logic             tdre_d, tend_d, rdrf_d;
  logic [ERR_W-1:0] err_q, err_d, snap_q, err_hit;
  logic             rx_take, rx_ovr;

  assign tx_valid = te_en & ~tdre_q;
  assign tx_take  = tx_valid & tx_ready;
  assign rx_ready = re_en;
  assign rx_take  = rx_valid & rx_ready;
  assign rx_ovr   = rx_take & rdrf_q;
  assign rx_store = rx_take & ~rdrf_q;
  assign tend_evt = tx_done & tdre_q;

  // error bit order: 0 parity, 1 framing, 2 overrun
  assign err_hit  = {rx_ovr, rx_break, rx_store & rx_perr};
  assign err_evt  = |err_hit;

  always_comb begin
    tdre_d = tdre_q;
    tend_d = tend_q;
    if (tx_take) begin
      tdre_d = 1'b1;
      tend_d = 1'b0;
    end
    if (tend_evt) tend_d = 1'b1;
    if (txd_we)   tdre_d = 1'b0;
    if (te_set) begin
      tdre_d = 1'b1;
      tend_d = 1'b1;
    end

    rdrf_d = rdrf_q;
    if (rxd_re)   rdrf_d = 1'b0;
    if (rx_store) rdrf_d = 1'b1;

    err_d = err_q;
    if (stat_we) err_d = err_q & (err_wd | ~snap_q);
    err_d = err_d | err_hit;
  end

  assign err_clr_evt = stat_we && (snap_q != '0) && (err_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
      rdrf_q <= 1'b0;
      mpbt_q <= 1'b0;
      err_q  <= '0;
      snap_q <= '0;
      rxd_q  <= '0;
    end else begin
      tdre_q <= tdre_d;
      tend_q <= tend_d;
      rdrf_q <= rdrf_d;
      err_q  <= err_d;
      if (stat_we)  mpbt_q <= mpbt_wd;
      if (stat_re)  snap_q <= err_q;
      if (rx_store) rxd_q  <= rx_data;
    end
  end

  always_comb begin
    stat_q = '0;
    stat_q[S_TDRE] = tdre_q;
    stat_q[S_RDRF] = rdrf_q;
    stat_q[S_ERR0 +: ERR_W] = err_q;
    stat_q[S_TEND] = tend_q;
    stat_q[S_MPB]  = 1'b0;
    stat_q[S_MPBT] = mpbt_q;
  end

  p_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !txd_we && !te_set) |=> (stat_q[S_TDRE] && !stat_q[S_TEND]));
  p_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_re && !(rx_valid && rx_ready)) |=> !stat_q[S_RDRF]);
  p_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && stat_q[S_RDRF]) |=> (stat_q[S_ERR0+2] && $stable(rxd_q)));
  p_stat_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !tx_valid && !tx_done && !rx_valid && !te_set && !rxd_re && !txd_we)
      |=> ($stable(stat_q[S_TDRE]) && $stable(stat_q[S_RDRF]) && $stable(stat_q[S_TEND])));
endmodule

// File: rtl/sio_irq.sv
module sio_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tie,
  input  logic teie,
  input  logic rie,
  input  logic ctrl_we,
  input  logic te_wd,
  input  logic tie_wd,
  input  logic teie_wd,
  input  logic rie_wd,
  input  logic tx_take,
  input  logic tend_evt,
  input  logic rx_store,
  input  logic err_evt,
  input  logic err_clr_evt,
  output logic irq_txi,
  output logic irq_rxi,
  output logic irq_tei,
  output logic irq_eri
);
  logic tei_d, eri_d;

  always_comb begin
    tei_d = irq_tei;
    if (tend_evt && teie)       tei_d = 1'b1;
    if (tx_take)                tei_d = 1'b0;
    if (ctrl_we && !teie_wd)    tei_d = 1'b0;

    eri_d = irq_eri;
    if (err_evt && rie)         eri_d = 1'b1;
    if (err_clr_evt)            eri_d = 1'b0;
    if (ctrl_we && !rie_wd)     eri_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_txi <= 1'b0;
      irq_rxi <= 1'b0;
      irq_tei <= 1'b0;
      irq_eri <= 1'b0;
    end else begin
      irq_txi <= (ctrl_we & te_wd & tie_wd) | (tx_take & tie);
      irq_rxi <= rx_store & rie;
      irq_tei <= tei_d;
      irq_eri <= eri_d;
    end
  end

  p_txi_on_te_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && te_wd && tie_wd) |=> irq_txi);
  p_rxi_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxi |=> !irq_rxi);
  p_tei_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !teie_wd) |=> !irq_tei);
  p_eri_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !rie_wd) |=> !irq_eri);
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int            ADDR_W   = 3,
  parameter logic [DW-1:0] BAUD_RST = '1,
  parameter logic [DW-1:0] TXD_RST  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_done,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_perr,
  input  logic              rx_break,
  output logic [DW-1:0]     cfg_mode,
  output logic [DW-1:0]     cfg_baud,
  output logic [DW-1:0]     cfg_ctrl,
  output logic [DW-1:0]     cfg_scm,
  output logic [DW-1:0]     cfg_ext,
  output logic              irq_rx_err,
  output logic              irq_rx_full,
  output logic              irq_tx_empty,
  output logic              irq_tx_end
);
  logic       in_map;
  ofs_e       ofs;
  logic       wr_en, rd_en;
  logic       mode_we, baud_we, ctrl_we, txd_we, stat_we, scm_we, ext_we;
  logic       stat_re, rxd_re;
  logic [DW-1:0] stat_q, rxd_q, txd_q;
  logic       tx_take, rx_store, err_evt, err_clr_evt, tend_evt;

  generate
    if (ADDR_W > 3) begin : g_hi
      assign in_map = ~|bus_addr[ADDR_W-1:3];
    end else begin : g_lo
      assign in_map = 1'b1;
    end
  endgenerate

  assign ofs   = ofs_e'(bus_addr[2:0]);
  assign wr_en = bus_sel & bus_wr & in_map;
  assign rd_en = bus_sel & ~bus_wr & in_map;

  assign mode_we = wr_en && (ofs == OFS_MODE);
  assign baud_we = wr_en && (ofs == OFS_BAUD);
  assign ctrl_we = wr_en && (ofs == OFS_CTRL);
  assign txd_we  = wr_en && (ofs == OFS_TXD);
  assign stat_we = wr_en && (ofs == OFS_STAT);
  assign scm_we  = wr_en && (ofs == OFS_SCM);
  assign ext_we  = wr_en && (ofs == OFS_EXT);
  assign stat_re = rd_en && (ofs == OFS_STAT);
  assign rxd_re  = rd_en && (ofs == OFS_RXD);

  sio_cfg_regs #(.BAUD_RST(BAUD_RST), .TXD_RST(TXD_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .baud_we(baud_we), .ctrl_we(ctrl_we),
    .txd_we(txd_we), .scm_we(scm_we), .ext_we(ext_we),
    .wdata(bus_wdata),
    .mode_q(cfg_mode), .baud_q(cfg_baud), .ctrl_q(cfg_ctrl),
    .txd_q(txd_q), .scm_q(cfg_scm), .ext_q(cfg_ext)
  );

  sio_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .te_en(cfg_ctrl[C_TE]), .re_en(cfg_ctrl[C_RE]),
    .txd_we(txd_we), .stat_we(stat_we), .stat_re(stat_re), .rxd_re(rxd_re),
    .te_set(ctrl_we & bus_wdata[C_TE]),
    .mpbt_wd(bus_wdata[S_MPBT]), .err_wd(bus_wdata[S_ERR0 +: ERR_W]),
    .tx_ready(tx_ready), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_break(rx_break), .rx_data(rx_data),
    .tx_valid(tx_valid), .rx_ready(rx_ready), .tx_take(tx_take),
    .stat_q(stat_q), .rxd_q(rxd_q),
    .rx_store(rx_store), .err_evt(err_evt), .err_clr_evt(err_clr_evt),
    .tend_evt(tend_evt)
  );

  sio_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .tie(cfg_ctrl[C_TIE]), .teie(cfg_ctrl[C_TEIE]), .rie(cfg_ctrl[C_RIE]),
    .ctrl_we(ctrl_we),
    .te_wd(bus_wdata[C_TE]), .tie_wd(bus_wdata[C_TIE]),
    .teie_wd(bus_wdata[C_TEIE]), .rie_wd(bus_wdata[C_RIE]),
    .tx_take(tx_take), .tend_evt(tend_evt), .rx_store(rx_store),
    .err_evt(err_evt), .err_clr_evt(err_clr_evt),
    .irq_txi(irq_tx_empty), .irq_rxi(irq_rx_full),
    .irq_tei(irq_tx_end), .irq_eri(irq_rx_err)
  );

  assign tx_data = txd_q;

  always_comb begin
    if (!in_map) begin
      bus_rdata = '1;
    end else begin
      unique case (ofs)
        OFS_MODE: bus_rdata = cfg_mode;
        OFS_BAUD: bus_rdata = cfg_baud;
        OFS_CTRL: bus_rdata = cfg_ctrl;
        OFS_TXD:  bus_rdata = txd_q;
        OFS_STAT: bus_rdata = stat_q;
        OFS_RXD:  bus_rdata = rxd_q;
        OFS_SCM:  bus_rdata = cfg_scm;
        default:  bus_rdata = cfg_ext;
      endcase
    end
  end

  p_eri_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_err |-> (stat_q[S_ERR0 +: ERR_W] != '0));
  p_tei_tend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_end |-> stat_q[S_TEND]);
  p_txv_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (cfg_ctrl[C_TE] && !stat_q[S_TDRE]));
endmodule

// File: tb/sio_regs_tb_top.sv
module sio_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       tx_valid, tx_ready = 1'b0, tx_done = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready, rx_perr = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] cfg_mode, cfg_baud, cfg_ctrl, cfg_scm, cfg_ext;
  logic       irq_rx_err, irq_rx_full, irq_tx_empty, irq_tx_end;

  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  sio_regs #(.ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_break(rx_break),
    .cfg_mode(cfg_mode), .cfg_baud(cfg_baud), .cfg_ctrl(cfg_ctrl),
    .cfg_scm(cfg_scm), .cfg_ext(cfg_ext),
    .irq_rx_err(irq_rx_err), .irq_rx_full(irq_rx_full),
    .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as each read strobe is seen
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_acc(input logic w, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_acc(1'b0, a, 8'h00);
  endtask

  task automatic mid;
    @(negedge clk);
  endtask

  task automatic tx_hand;
    @(posedge clk); #2; tx_ready = 1'b1;
    @(posedge clk); #2; tx_ready = 1'b0;
  endtask

  task automatic tx_fin;
    @(posedge clk); #2; tx_done = 1'b1;
    @(posedge clk); #2; tx_done = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d, input logic pe);
    @(posedge clk); #2; rx_valid = 1'b1; rx_data = d; rx_perr = pe;
    @(posedge clk); #2; rx_valid = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic rx_brk;
    @(posedge clk); #2; rx_break = 1'b1;
    @(posedge clk); #2; rx_break = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    mid;
    chk("R1 irq lines", {4'h0, irq_rx_err, irq_rx_full, irq_tx_empty, irq_tx_end}, 8'h00);
    chk("R1 tx_valid", {7'h0, tx_valid}, 8'h00);
    rd(0, 8'h00, "R1 mode"); rd(1, 8'hFF, "R1 baud"); rd(2, 8'h00, "R1 ctrl");
    rd(3, 8'hFF, "R1 txd");  rd(4, 8'h84, "R1 status"); rd(5, 8'h00, "R1 rxd");
    rd(6, 8'h00, "R1 scm");  rd(7, 8'h00, "R1 ext");

    // R12 unmapped offsets
    rd(9, 8'hFF, "R12 read 9"); rd(15, 8'hFF, "R12 read 15");
    wr(8, 8'h5A);
    rd(0, 8'h00, "R12 mode untouched"); rd(1, 8'hFF, "R12 baud untouched");

    // R2 unlocked writes, R13 pass-through
    wr(0, 8'h5A); wr(1, 8'h33);
    rd(0, 8'h5A, "R2 mode unlocked"); rd(1, 8'h33, "R2 baud unlocked");
    wr(6, 8'hA5); wr(7, 8'h3C);
    rd(6, 8'hA5, "R13 scm"); rd(7, 8'h3C, "R13 ext");
    mid; chk("R13 cfg_scm", cfg_scm, 8'hA5);

    // R4 write with transmit disabled
    wr(3, 8'h77);
    mid; chk("R4 tx_valid with TE off", {7'h0, tx_valid}, 8'h00);
    rd(4, 8'h04, "R4 status after txd write"); rd(3, 8'h77, "R4 txd");

    // R2 lock by receive enable
    wr(2, 8'h10);
    mid; chk("R6 rx_ready", {7'h0, rx_ready}, 8'h01);
    wr(0, 8'h11); wr(1, 8'h44);
    rd(0, 8'h5A, "R2 mode locked"); rd(1, 8'h33, "R2 baud locked");

    // R3 enable transmit with interrupts
    wr(2, 8'hF4);
    mid; chk("R3 txi pulse", {7'h0, irq_tx_empty}, 8'h01);
    rd(4, 8'h84, "R3 status forced");
    mid; chk("R3 cfg_ctrl", cfg_ctrl, 8'hF4);
    wr(0, 8'h22); rd(0, 8'h5A, "R2 mode locked by TE");

    // R4 stream handshake
    wr(3, 8'hC3);
    mid; chk("R4 tx_valid", {7'h0, tx_valid}, 8'h01); chk("R4 tx_data", tx_data, 8'hC3);
    rd(4, 8'h04, "R4 status pending");
    tx_hand;
    mid; chk("R4 txi on take", {7'h0, irq_tx_empty}, 8'h01);
    chk("R4 tx_valid after take", {7'h0, tx_valid}, 8'h00);
    rd(4, 8'h80, "R4 status after take");

    // R5 transmit end
    tx_fin;
    mid; chk("R5 tei rise", {7'h0, irq_tx_end}, 8'h01);
    rd(4, 8'h84, "R5 status tend");
    wr(2, 8'hF0);
    mid; chk("R5 tei drop by ctrl", {7'h0, irq_tx_end}, 8'h00);
    wr(2, 8'hF4);
    wr(3, 8'h21); tx_hand;
    rd(4, 8'h80, "R5 status after second take");
    wr(3, 8'h22); rd(4, 8'h00, "R5 status pending");
    tx_fin;
    mid; chk("R5 tx_done ignored tei", {7'h0, irq_tx_end}, 8'h00);
    rd(4, 8'h00, "R5 tx_done ignored status");
    tx_hand; rd(4, 8'h80, "R5 status after third take");
    tx_fin;
    mid; chk("R5 tei rise again", {7'h0, irq_tx_end}, 8'h01);
    rd(4, 8'h84, "R5 status tend again");

    // R6 receive, R9 read clears
    rx_send(8'h5E, 1'b0);
    mid; chk("R6 rxi pulse", {7'h0, irq_rx_full}, 8'h01);
    rd(4, 8'hC4, "R6 status full");
    rd(5, 8'h5E, "R9 rxd");
    rd(4, 8'h84, "R9 status cleared");

    // R8 break, R10/R11 clear handshake
    rx_brk;
    mid; chk("R8 eri on break", {7'h0, irq_rx_err}, 8'h01);
    wr(4, 8'h00);
    mid; chk("R11 eri kept without read", {7'h0, irq_rx_err}, 8'h01);
    rd(4, 8'h94, "R10 fer kept without read");
    wr(4, 8'h01);
    mid; chk("R11 eri released", {7'h0, irq_rx_err}, 8'h00);
    rd(4, 8'h85, "R10 fer cleared, mpbt set");
    wr(4, 8'hFF);
    rd(4, 8'h85, "R10 ones do not set");

    // R7 overrun
    rx_send(8'h01, 1'b0);
    rd(4, 8'hC5, "R7 first byte stored");
    rx_send(8'h02, 1'b0);
    mid; chk("R7 eri on overrun", {7'h0, irq_rx_err}, 8'h01);
    chk("R7 no rxi on overrun", {7'h0, irq_rx_full}, 8'h00);
    rd(4, 8'hE5, "R7 status overrun");
    rd(5, 8'h01, "R7 rxd kept");
    rd(4, 8'hA5, "R7 status after rxd read");
    wr(4, 8'h00);
    mid; chk("R11 eri released after overrun", {7'h0, irq_rx_err}, 8'h00);
    rd(4, 8'h84, "R10 overrun cleared");

    // R8 parity, R11 ctrl release, R6 gating
    rx_send(8'h33, 1'b1);
    mid; chk("R8 eri on parity", {7'h0, irq_rx_err}, 8'h01);
    chk("R6 rxi on parity byte", {7'h0, irq_rx_full}, 8'h01);
    rd(4, 8'hCC, "R8 status parity");
    wr(2, 8'hB4);
    mid; chk("R11 eri drop by ctrl", {7'h0, irq_rx_err}, 8'h00);
    rd(5, 8'h33, "R8 rxd parity byte");
    rd(4, 8'h8C, "R9 status after read");
    rx_send(8'h44, 1'b0);
    mid; chk("R6 rxi gated off", {7'h0, irq_rx_full}, 8'h00);
    rd(4, 8'hCC, "R6 status full gated");
    rd(5, 8'h44, "R6 rxd");
    wr(5, 8'h99);
    rd(5, 8'h44, "R9 rxd write ignored");

    // disable and unlock
    wr(2, 8'h00);
    mid; chk("R5 tei drop on disable", {7'h0, irq_tx_end}, 8'h00);
    chk("R6 rx_ready off", {7'h0, rx_ready}, 8'h00);
    chk("R4 tx_valid off", {7'h0, tx_valid}, 8'h00);
    wr(0, 8'h11); rd(0, 8'h11, "R2 mode unlocked again");

    repeat (2) @(posedge clk);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    finished = 1'b1;
    summary;
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0x00 expected 0x01 (run did not complete)");
      summary;
      $finish;
    end
  end
endmodule